// File: doc/BRIEF.md
# Data-Processing ALU with Status Flags

This block is the integer execution stage of a small load/store processor core. Each cycle it takes a 4-bit operation code, a first operand, and a second operand that the shifter has already prepared (or that is an immediate). It returns a result together with a register-write enable, and it holds the four status flags (negative, zero, carry, overflow) in a register of its own. The carry input of the carry-consuming operations comes from that stored carry flag. The carry-out of the shifter enters on a separate pin and becomes the carry flag for the move and logical operations.

The operations fall into four groups: moves, arithmetic (add and subtract in plain, with-carry and reverse forms), bitwise logic (including bit-clear), and compare/test. The compare/test group updates only the flags. The other groups write a result, and they change the flags only when the caller asks for it. The result and the next flag value are combinational. The flag register loads the next value on every rising clock edge.

Top module: `dp_alu_flags`

## Requirements
- R1: While `rst_n` is low, the stored flags `flags_q` are 4'b0000. The flag vectors are packed as bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V.
- R2: Opcode 0 (move) returns `opnd_b` and opcode 1 (move-not) returns `~opnd_b`. `opnd_a` has no effect on either.
- R3: Opcode 2 (add) returns a+b. Opcode 3 (add-with-carry) returns a+b+C, where C is the stored carry flag.
- R4: Opcode 4 (subtract) returns a-b. Opcode 5 (subtract-with-carry) returns a-b-(1-C). For both, C is 1 exactly when the unsigned subtraction does not borrow.
- R5: Opcode 6 (reverse subtract) returns b-a. Opcode 7 (reverse subtract-with-carry) returns b-a-(1-C). C again means no borrow.
- R6: Opcodes 8, 9, 10 and 11 return a AND b, a XOR b, a OR b and a AND NOT b.
- R7: Opcodes 12 (a+b), 13 (a-b), 14 (a XOR b) and 15 (a AND b) drive that value on `result` and hold `wr_en` low. They update the flags whatever the state of `set_flags`. Every other opcode holds `wr_en` high.
- R8: For opcodes 0 to 11 with `set_flags` low, `flags_next` equals `flags_q`, and the stored flags are unchanged after the clock edge.
- R9: When the flags update, N equals the most significant bit of `result`, and Z is 1 exactly when `result` is zero.
- R10: When the flags update, arithmetic opcodes (2 to 7, 12, 13) set C from the adder carry-out and V from signed overflow. Move, logic and test opcodes (0, 1, 8 to 11, 14, 15) take C from `shift_cout` and keep the stored V.
- R11: At each rising edge out of reset, `flags_q` takes the value `flags_next` had before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the flag register |
| op_code | input | 4 | Operation select, encoded as listed in R2 to R7 |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, already shifted or immediate |
| shift_cout | input | 1 | Carry-out of the shifter, used as C by move, logic and test operations |
| set_flags | input | 1 | Request to update the flags for opcodes 0 to 11 |
| result | output | 32 | Operation result |
| wr_en | output | 1 | High when the result is to be written to a register |
| flags_next | output | 4 | Flag value the register loads at the next edge (N,Z,C,V) |
| flags_q | output | 4 | Stored flags (N,Z,C,V) |

## Verification
The bench builds the block with a 32-bit data path and selects the ripple-carry adder variant. This exercises the generate branch that forms carry and overflow from an explicit carry chain, while the default single-expression adder is covered by elaboration with default parameters. With a 32-bit width, the directed values reach the sign boundary (0x7FFFFFFF + 1, 0x80000000 - 1) and the unsigned wrap (0xFFFFFFFF + 1). These cases give distinct N, Z, C and V patterns. Chaining operations then shows the stored carry feeding the with-carry forms in both of its states.

// File: rtl/dpalu_pkg.sv
package dpalu_pkg;

   typedef enum logic [3:0] {
      OP_MOVE  = 4'd0,
      OP_MOVN  = 4'd1,
      OP_ADD   = 4'd2,
      OP_ADDC  = 4'd3,
      OP_SUB   = 4'd4,
      OP_SUBC  = 4'd5,
      OP_RSUB  = 4'd6,
      OP_RSUBC = 4'd7,
      OP_AND   = 4'd8,
      OP_XOR   = 4'd9,
      OP_OR    = 4'd10,
      OP_BCLR  = 4'd11,
      OP_CMPN  = 4'd12,
      OP_CMP   = 4'd13,
      OP_TEQ   = 4'd14,
      OP_TST   = 4'd15
   } alu_op_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } flags_t;

   // compare/test group: flags only, no register write
   function automatic logic op_is_compare(input alu_op_e op);
      return (op == OP_CMPN) || (op == OP_CMP) || (op == OP_TEQ) || (op == OP_TST);
   endfunction

   // operations whose result comes from the adder
   function automatic logic op_uses_adder(input alu_op_e op);
      return (op == OP_ADD) || (op == OP_ADDC) || (op == OP_SUB) || (op == OP_SUBC) ||
             (op == OP_RSUB) || (op == OP_RSUBC) || (op == OP_CMPN) || (op == OP_CMP);
   endfunction

endpackage

// File: rtl/dpalu_operand_mux.sv
module dpalu_operand_mux
   import dpalu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  alu_op_e            op,
   input  logic [WIDTH-1:0]   a,
   input  logic [WIDTH-1:0]   b,
   input  logic               carry_flag,
   output logic [WIDTH-1:0]   x,
   output logic [WIDTH-1:0]   y,
   output logic               cin
);

   // subtraction is done as x + ~y + cin; borrow-in is the inverted stored carry
   always_comb begin
      x   = a;
      y   = b;
      cin = 1'b0;
      unique case (op)
         OP_ADDC:         cin = carry_flag;
         OP_SUB, OP_CMP:  begin y = ~b; cin = 1'b1; end
         OP_SUBC:         begin y = ~b; cin = carry_flag; end
         OP_RSUB:         begin x = b; y = ~a; cin = 1'b1; end
         OP_RSUBC:        begin x = b; y = ~a; cin = carry_flag; end
         default:         ;
      endcase
   end

endmodule

// File: rtl/dpalu_adder.sv
module dpalu_adder #(
   parameter int WIDTH  = 32,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             ovf
);

   localparam int MSB = WIDTH - 1;

   generate
      if (RIPPLE) begin : g_ripple
         logic [WIDTH:0] chain;
         assign chain[0] = cin;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i]     = x[i] ^ y[i] ^ chain[i];
            assign chain[i+1] = (x[i] & y[i]) | (chain[i] & (x[i] ^ y[i]));
         end
         assign cout = chain[WIDTH];
         assign ovf  = chain[WIDTH] ^ chain[MSB];
      end else begin : g_flat
         logic [WIDTH:0] wide;
         assign wide = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
         assign sum  = wide[MSB:0];
         assign cout = wide[WIDTH];
         assign ovf  = (x[MSB] == y[MSB]) && (wide[MSB] != x[MSB]);
      end
   endgenerate

endmodule

// File: rtl/dpalu_logic.sv
module dpalu_logic
   import dpalu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  alu_op_e          op,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] res
);

   always_comb begin
      unique case (op)
         OP_MOVE:         res = b;
         OP_MOVN:         res = ~b;
         OP_AND, OP_TST:  res = a & b;
         OP_XOR, OP_TEQ:  res = a ^ b;
         OP_OR:           res = a | b;
         OP_BCLR:         res = a & ~b;
         default:         res = '0;
      endcase
   end

endmodule

// File: rtl/dpalu_flag_reg.sv
module dpalu_flag_reg
   import dpalu_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  flags_t d,
   output flags_t q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end

endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
   import dpalu_pkg::*;
#(
   parameter int WIDTH  = 32,
   parameter bit RIPPLE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       op_code,
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  logic             shift_cout,
   input  logic             set_flags,
   output logic [WIDTH-1:0] result,
   output logic             wr_en,
   output logic [3:0]       flags_next,
   output logic [3:0]       flags_q
);

   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("dp_alu_flags: WIDTH must be at least 2");
      end
   endgenerate

   alu_op_e          op;
   flags_t           fq, fn, fcalc;
   logic [WIDTH-1:0] add_x, add_y, add_sum, log_res;
   logic             add_cin, add_cout, add_ovf;
   logic             is_cmp, use_add, upd;

   assign op      = alu_op_e'(op_code);
   assign is_cmp  = op_is_compare(op);
   assign use_add = op_uses_adder(op);
   assign upd     = set_flags | is_cmp;

   dpalu_operand_mux #(.WIDTH(WIDTH)) u_mux (
      .op         (op),
      .a          (opnd_a),
      .b          (opnd_b),
      .carry_flag (fq.c),
      .x          (add_x),
      .y          (add_y),
      .cin        (add_cin)
   );

   dpalu_adder #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_add (
      .x    (add_x),
      .y    (add_y),
      .cin  (add_cin),
      .sum  (add_sum),
      .cout (add_cout),
      .ovf  (add_ovf)
   );

   dpalu_logic #(.WIDTH(WIDTH)) u_log (
      .op  (op),
      .a   (opnd_a),
      .b   (opnd_b),
      .res (log_res)
   );

   always_comb begin
      result  = use_add ? add_sum : log_res;
      fcalc.n = result[MSB];
      fcalc.z = (result == '0);
      fcalc.c = use_add ? add_cout : shift_cout;
      fcalc.v = use_add ? add_ovf  : fq.v;
      fn      = upd ? fcalc : fq;
   end

   dpalu_flag_reg u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (fn),
      .q     (fq)
   );

   assign wr_en      = ~is_cmp;
   assign flags_next = fn;
   assign flags_q    = fq;

endmodule

// File: rtl/dpalu_checker.sv
module dpalu_checker #(
   parameter int WIDTH = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [3:0]       op_code,
   input logic             set_flags,
   input logic             shift_cout,
   input logic [WIDTH-1:0] result,
   input logic             wr_en,
   input logic [3:0]       flags_next,
   input logic [3:0]       flags_q
);

   logic cmp_grp, arith_grp, upd;
   assign cmp_grp   = (op_code[3:2] == 2'b11);
   assign arith_grp = ((op_code >= 4'd2) && (op_code <= 4'd7)) ||
                      (op_code == 4'd12) || (op_code == 4'd13);
   assign upd       = set_flags || cmp_grp;

   a_r7_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_grp |-> !wr_en);

   a_r7_other_write: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_grp |-> wr_en);

   a_r8_hold_flags: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> flags_q == $past(flags_q));

   a_r9_n_msb: assert property (@(posedge clk) disable iff (!rst_n)
      upd |-> flags_next[3] == result[WIDTH-1]);

   a_r9_z_zero: assert property (@(posedge clk) disable iff (!rst_n)
      upd |-> flags_next[2] == (result == '0));

   a_r10_v_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !arith_grp) |-> flags_next[0] == flags_q[0]);

   a_r10_c_shift: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !arith_grp) |-> flags_next[1] == shift_cout);

   a_r11_reg_load: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> flags_q == $past(flags_next));

endmodule

bind dp_alu_flags dpalu_checker #(.WIDTH(WIDTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .op_code    (op_code),
   .set_flags  (set_flags),
   .shift_cout (shift_cout),
   .result     (result),
   .wr_en      (wr_en),
   .flags_next (flags_next),
   .flags_q    (flags_q)
);

// File: tb/dp_alu_flags_tb_top.sv
module dp_alu_flags_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [3:0]   op_code = '0;
   logic [W-1:0] opnd_a = '0, opnd_b = '0;
   logic         shift_cout = 1'b0, set_flags = 1'b0;
   logic [W-1:0] result;
   logic         wr_en;
   logic [3:0]   flags_next, flags_q;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dp_alu_flags #(.WIDTH(W), .RIPPLE(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .shift_cout(shift_cout), .set_flags(set_flags), .result(result), .wr_en(wr_en),
      .flags_next(flags_next), .flags_q(flags_q)
   );

   task automatic chk(input string req, input string what, input logic [W-1:0] act,
                      input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // drive on falling edge, check combinational outputs, then the stored flags after the edge
   task automatic run_op(input string req, input logic [3:0] op, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic sc, input logic sf,
                         input logic [W-1:0] exp_res, input logic exp_we,
                         input logic [3:0] exp_fl);
      @(negedge clk);
      op_code = op; opnd_a = a; opnd_b = b; shift_cout = sc; set_flags = sf;
      #2;
      chk(req, "result", result, exp_res);
      chk(req, "wr_en", {31'b0, wr_en}, {31'b0, exp_we});
      chk(req, "flags_next", {28'b0, flags_next}, {28'b0, exp_fl});
      @(posedge clk);
      #1;
      chk(req, "flags_q", {28'b0, flags_q}, {28'b0, exp_fl});
   endtask

   task automatic t_reset;
      #1;
      chk("R1", "flags in reset", {28'b0, flags_q}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_move;
      run_op("R2", 4'd0, 32'hDEAD_BEEF, 32'h8000_0000, 1'b1, 1'b1, 32'h8000_0000, 1'b1, 4'b1010);
      run_op("R2", 4'd1, 32'h0000_1234, 32'hFFFF_FFFF, 1'b0, 1'b1, 32'h0000_0000, 1'b1, 4'b0100);
   endtask

   task automatic t_add;
      run_op("R3_R10", 4'd2, 32'h7FFF_FFFF, 32'h1, 1'b0, 1'b1, 32'h8000_0000, 1'b1, 4'b1001);
      run_op("R3_R9", 4'd2, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b1, 32'h0, 1'b1, 4'b0110);
      run_op("R3 carry1", 4'd3, 32'd5, 32'd6, 1'b0, 1'b1, 32'd12, 1'b1, 4'b0000);
      run_op("R3 carry0", 4'd3, 32'd5, 32'd6, 1'b0, 1'b1, 32'd11, 1'b1, 4'b0000);
   endtask

   task automatic t_noflag;
      run_op("R8", 4'd2, 32'hFFFF_FFFF, 32'h1, 1'b1, 1'b0, 32'h0, 1'b1, 4'b0000);
   endtask

   task automatic t_sub;
      run_op("R4", 4'd4, 32'd5, 32'd3, 1'b0, 1'b1, 32'd2, 1'b1, 4'b0010);
      run_op("R4 borrow", 4'd4, 32'd3, 32'd5, 1'b0, 1'b1, 32'hFFFF_FFFE, 1'b1, 4'b1000);
      run_op("R4 subc C0", 4'd5, 32'd10, 32'd3, 1'b0, 1'b1, 32'd6, 1'b1, 4'b0010);
      run_op("R4 subc C1", 4'd5, 32'd10, 32'd3, 1'b0, 1'b1, 32'd7, 1'b1, 4'b0010);
      run_op("R4_R10 ovf", 4'd4, 32'h8000_0000, 32'h1, 1'b0, 1'b1, 32'h7FFF_FFFF, 1'b1, 4'b0011);
   endtask

   task automatic t_rsub;
      run_op("R5", 4'd6, 32'd3, 32'd10, 1'b0, 1'b1, 32'd7, 1'b1, 4'b0010);
      run_op("R5 borrow", 4'd6, 32'd10, 32'd3, 1'b0, 1'b1, 32'hFFFF_FFF9, 1'b1, 4'b1000);
      run_op("R5 rsubc C0", 4'd7, 32'd3, 32'd10, 1'b0, 1'b1, 32'd6, 1'b1, 4'b0010);
      run_op("R4_R10 ovf", 4'd4, 32'h8000_0000, 32'h1, 1'b0, 1'b1, 32'h7FFF_FFFF, 1'b1, 4'b0011);
   endtask

   task automatic t_logic;
      run_op("R6_R10 and", 4'd8, 32'hF0F0_F0F0, 32'hFF00_FF00, 1'b0, 1'b1, 32'hF000_F000, 1'b1, 4'b1001);
      run_op("R6 xor", 4'd9, 32'hAAAA_AAAA, 32'h5555_5555, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b1, 4'b1011);
      run_op("R6_R9 or", 4'd10, 32'h0, 32'h0, 1'b0, 1'b1, 32'h0, 1'b1, 4'b0101);
      run_op("R6 bclr", 4'd11, 32'hFFFF_0000, 32'h0F0F_0F0F, 1'b0, 1'b1, 32'hF0F0_0000, 1'b1, 4'b1001);
   endtask

   task automatic t_compare;
      run_op("R7 cmp", 4'd13, 32'd5, 32'd5, 1'b0, 1'b0, 32'h0, 1'b0, 4'b0110);
      run_op("R7 cmpn", 4'd12, 32'h7FFF_FFFF, 32'h1, 1'b0, 1'b0, 32'h8000_0000, 1'b0, 4'b1001);
      run_op("R7_R10 teq", 4'd14, 32'h1234, 32'h1234, 1'b1, 1'b0, 32'h0, 1'b0, 4'b0111);
      run_op("R7 tst", 4'd15, 32'hF0, 32'h0F, 1'b0, 1'b0, 32'h0, 1'b0, 4'b0101);
      run_op("R7_R11 tst", 4'd15, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, 32'h8000_0000, 1'b0, 4'b1001);
   endtask

   initial begin
      t_reset();
      t_move();
      t_add();
      t_noflag();
      t_sub();
      t_rsub();
      t_logic();
      t_compare();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 5000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule